// File: doc/BRIEF.md
# Vector Any-Element Equality Search

This block compares two 128-bit vector operands that are split into equal elements of 8, 16 or 32 bits. Each element of the first operand (A) is tested against every element of the second operand (B). An element of A "hits" when it equals at least one element of B, at any position. An invert flag can complement these per-element hit indications.

The block has two result formats. In index mode it reports the byte offset of the earliest event, which is either the first hit or, when zero-search is on, the first all-zero element of A. In mask mode it returns a vector in which each element is all ones where it hit. A 2-bit condition code summarises the outcome so that surrounding logic can branch on it.

One operation is accepted per cycle. Result, code and error flag are registered and appear one clock after the input strobe.

Top module: `vec_any_eq_search`

## Requirements
- R1: Bytes are numbered from the most significant end: byte 0 is bits 127:120. An element of A starting at byte k hits when it equals any element of B, wherever that element sits. The index it reports is k.
- R2: In index mode (ctrl bit 2 = 0), result bits 127:64 hold the smaller of the first-hit byte offset and the first-zero byte offset, and bits 63:0 are zero. The value 16 means neither was found.
- R3: With ctrl bit 3 set, each element's hit indication is complemented before the index, mask or condition code is formed.
- R4: In mask mode (ctrl bit 2 = 1), each element of the result is all ones when that element hit and all zeros otherwise.
- R5: With ctrl bit 1 set, the first element of A whose value is zero is located. With it clear, the zero position is taken as 16.
- R6: The condition code is 3 when there is neither a hit nor a zero. It is 1 when there is a hit but no zero. It is 2 when the first hit is at a lower offset than the first zero. Otherwise it is 0.
- R7: The flags are read from the ctrl port by bit position: bit 3 invert, bit 2 mask mode, bit 1 zero-search.
- R8: The es input selects the element width: 0 selects 8 bits, 1 selects 16 bits and 2 selects 32 bits.
- R9: out_valid rises one clock after in_valid is sampled high and is low one clock after it is sampled low. When in_valid is low, result, cc and es_err hold their values.
- R10: A synchronous active-high reset clears out_valid, result, cc and es_err to zero.
- R11: es = 3 is illegal. It sets es_err, gives a zero result and gives cc = 3. The next legal operation clears es_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| es | input | 2 | Element size code |
| ctrl | input | 3 (bits 3:1) | Flags: 3 invert, 2 mask mode, 1 zero-search |
| opa | input | 128 | Searched operand A |
| opb | input | 128 | Set operand B |
| out_valid | output | 1 | Result registered this cycle |
| result | output | 128 | Index or mask result |
| cc | output | 2 | Condition code |
| es_err | output | 1 | Illegal element size was presented |

## Verification
The bench sweeps every element size against every flag combination. The operands are drawn from a small byte alphabet, so hits, zeros and misses all occur. Some operands are built so that B is a rotated copy of A, which forces hits at positions other than the matching one.

A design that compared elements only at equal positions would miss those rotated hits. A design that indexed elements rather than bytes would give wrong offsets at 16 and 32 bits. A design that applied the inversion after computing the code would misreport cc. A design that treated the tie or the no-zero case in the wrong order would confuse codes 0, 1 and 2.

Further directed cases cover the zero-search switch, the illegal size and the hold of results between strobes.

// File: rtl/vfa_pkg.sv
package vfa_pkg;

  typedef struct packed {
    logic inv;
    logic mask_mode;
    logic zsrch;
  } vfa_flags_t;

  // Flag positions are fixed by the control word layout: 3, 2, 1.
  function automatic vfa_flags_t decode_flags(input logic [3:1] c);
    vfa_flags_t f;
    f.inv       = c[3];
    f.mask_mode = c[2];
    f.zsrch     = c[1];
    return f;
  endfunction

  // Four-way outcome code from the two byte positions; none marks absence.
  function automatic logic [1:0] cc_of(input int hit, input int zero, input int none);
    if (hit == none && zero == none) return 2'd3;
    if (zero == none)                return 2'd1;
    if (hit < zero)                  return 2'd2;
    return 2'd0;
  endfunction

endpackage

// File: rtl/vfa_elem_cmp.sv
module vfa_elem_cmp #(
  parameter int VEC_BYTES = 16,
  parameter int EB = 1,
  localparam int NE = VEC_BYTES / EB,
  localparam int EW = EB * 8,
  localparam int VW = VEC_BYTES * 8
) (
  input  logic [VW-1:0] a,
  input  logic [VW-1:0] b,
  output logic [NE-1:0] hit,
  output logic [NE-1:0] zero
);
  // Element i occupies the i-th EW-bit slot counted from the top.
  for (genvar gi = 0; gi < NE; gi++) begin : g_row
    logic [EW-1:0] ea;
    logic [NE-1:0] eq_row;
    assign ea = a[VW-1-gi*EW -: EW];
    for (genvar gj = 0; gj < NE; gj++) begin : g_col
      assign eq_row[gj] = (ea == b[VW-1-gj*EW -: EW]);
    end
    assign hit[gi]  = |eq_row;
    assign zero[gi] = (ea == '0);
  end
endmodule

// File: rtl/vfa_first.sv
module vfa_first #(
  parameter int N = 16,
  parameter int IW = $clog2(N + 1)
) (
  input  logic [N-1:0]  vec,
  output logic [IW-1:0] idx
);
  // Lowest set position wins; N when nothing is set.
  always_comb begin
    idx = IW'(N);
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/vec_any_eq_search.sv
module vec_any_eq_search
  import vfa_pkg::*;
#(
  parameter int VEC_BYTES = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic [1:0]             es,
  input  logic [3:1]             ctrl,
  input  logic [VEC_BYTES*8-1:0] opa,
  input  logic [VEC_BYTES*8-1:0] opb,
  output logic                   out_valid,
  output logic [VEC_BYTES*8-1:0] result,
  output logic [1:0]             cc,
  output logic                   es_err
);
  localparam int VW   = VEC_BYTES * 8;
  localparam int HALF = VW / 2;
  localparam int IW   = $clog2(VEC_BYTES + 1);
  localparam int NSZ  = 3;

  vfa_flags_t flags;
  assign flags = decode_flags(ctrl);

  logic [IW-1:0] hit_byte  [4];
  logic [IW-1:0] zero_byte [4];
  logic [VW-1:0] mask_v    [4];

  // One comparison array per legal element size.
  for (genvar k = 0; k < NSZ; k++) begin : g_size
    localparam int EB  = 1 << k;
    localparam int EW  = EB * 8;
    localparam int NE  = VEC_BYTES / EB;
    localparam int EIW = $clog2(NE + 1);
    logic [NE-1:0]  raw_hit, hit, zero, zero_used;
    logic [EIW-1:0] fh, fz;
    logic [VW-1:0]  m;

    vfa_elem_cmp #(.VEC_BYTES(VEC_BYTES), .EB(EB)) u_cmp (
      .a(opa), .b(opb), .hit(raw_hit), .zero(zero)
    );
    assign hit       = flags.inv ? ~raw_hit : raw_hit;
    assign zero_used = flags.zsrch ? zero : '0;

    vfa_first #(.N(NE), .IW(EIW)) u_fh (.vec(hit),       .idx(fh));
    vfa_first #(.N(NE), .IW(EIW)) u_fz (.vec(zero_used), .idx(fz));

    // Element index times element bytes; the "none" value NE maps to VEC_BYTES.
    assign hit_byte[k]  = IW'(fh) << k;
    assign zero_byte[k] = IW'(fz) << k;

    for (genvar gi = 0; gi < NE; gi++) begin : g_mask
      assign m[VW-1-gi*EW -: EW] = {EW{hit[gi]}};
    end
    assign mask_v[k] = m;
  end
  assign hit_byte[3]  = IW'(VEC_BYTES);
  assign zero_byte[3] = IW'(VEC_BYTES);
  assign mask_v[3]    = '0;

  // Named events used by the assertions below.
  logic          err_in;
  logic [IW-1:0] hit_first, zero_first, first_evt;
  logic [1:0]    next_cc;
  logic [VW-1:0] next_res;

  assign err_in     = (es == 2'd3);
  assign hit_first  = hit_byte[es];
  assign zero_first = zero_byte[es];
  assign first_evt  = (hit_first < zero_first) ? hit_first : zero_first;

  always_comb begin
    if (err_in) begin
      next_cc  = 2'd3;
      next_res = '0;
    end else begin
      next_cc  = cc_of(int'(hit_first), int'(zero_first), VEC_BYTES);
      next_res = flags.mask_mode ? mask_v[es] : {HALF'(first_evt), HALF'(0)};
    end
  end

  logic mode_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      cc        <= 2'd0;
      es_err    <= 1'b0;
      mode_q    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result <= next_res;
        cc     <= next_cc;
        es_err <= err_in;
        mode_q <= flags.mask_mode;
      end
    end
  end

  p_valid_rise_r9: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_valid_fall_r9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(result) && $stable(cc) && $stable(es_err)));
  p_illegal_size_r11: assert property (@(posedge clk) disable iff (rst)
    (in_valid && err_in) |=> (es_err && result == '0 && cc == 2'd3));
  p_index_shape_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !err_in && !flags.mask_mode) |=>
      (result[HALF-1:0] == '0 && result[VW-1:HALF] <= HALF'(VEC_BYTES)));
  p_none_code_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !es_err && !mode_q) |->
      ((cc == 2'd3) == (result[VW-1:HALF] == HALF'(VEC_BYTES))));
  p_zero_off_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !err_in && !flags.zsrch) |=> (cc == 2'd1 || cc == 2'd3));
endmodule

// File: tb/vec_any_eq_search_bench.sv
`timescale 1ns/1ps
module vec_any_eq_search_bench;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [1:0]   es = 2'd0;
  logic [3:1]   ctrl = 3'd0;
  logic [127:0] opa = '0;
  logic [127:0] opb = '0;
  logic         out_valid;
  logic [127:0] result;
  logic [1:0]   cc;
  logic         es_err;

  int checks = 0;
  int fails = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #4 clk = ~clk;

  vec_any_eq_search u_vec_any_eq_search (
    .clk(clk), .rst(rst), .in_valid(in_valid), .es(es), .ctrl(ctrl),
    .opa(opa), .opb(opb), .out_valid(out_valid), .result(result),
    .cc(cc), .es_err(es_err)
  );

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic next_rand(output logic [31:0] v);
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    v = seed;
  endtask

  // Independent model: slices elements by shifting, scans loops in order.
  function automatic void model(input logic [1:0] e, input logic [3:1] c,
                                input logic [127:0] a, input logic [127:0] b,
                                output logic [127:0] r, output logic [1:0] cx);
    int eb = 1 << e;
    int ne = 16 / eb;
    int ew = eb * 8;
    logic [31:0] emask = (ew == 32) ? 32'hffff_ffff : ((32'h1 << ew) - 32'h1);
    logic [31:0] x, y;
    int fh = 16;
    int fz = 16;
    int mn;
    bit h;
    r = '0;
    for (int i = 0; i < ne; i++) begin
      x = 32'(a >> (128 - (i + 1) * ew)) & emask;
      h = 1'b0;
      for (int j = 0; j < ne; j++) begin
        y = 32'(b >> (128 - (j + 1) * ew)) & emask;
        if (x == y) h = 1'b1;
      end
      if (c[3]) h = !h;
      if (h && fh == 16) fh = i * eb;
      if (h) r = r | (128'(emask) << (128 - (i + 1) * ew));
      if (c[1] && x == 0 && fz == 16) fz = i * eb;
    end
    mn = (fh < fz) ? fh : fz;
    if (!c[2]) r = {64'(mn), 64'h0};
    if (fh == 16 && fz == 16) cx = 2'd3;
    else if (fz == 16)        cx = 2'd1;
    else if (fh < fz)         cx = 2'd2;
    else                      cx = 2'd0;
  endfunction

  task automatic apply(input logic [1:0] e, input logic [3:1] c,
                       input logic [127:0] a, input logic [127:0] b);
    @(negedge clk);
    es = e; ctrl = c; opa = a; opb = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_model(input logic [1:0] e, input logic [3:1] c,
                           input logic [127:0] a, input logic [127:0] b);
    logic [127:0] er;
    logic [1:0]   ec;
    model(e, c, a, b, er, ec);
    apply(e, c, a, b);
    chk(out_valid == 1'b1, "R9 out_valid after strobe", 128'(out_valid), 128'(1));
    chk(es_err == 1'b0, "R8 legal size flags no error", 128'(es_err), 128'(0));
    if (c[2]) chk(result == er, "R4 mask result", result, er);
    else      chk(result == er, "R2 index result", result, er);
    chk(cc == ec, "R6 condition code", 128'(cc), 128'(ec));
  endtask

  task automatic make_ops(input int p, input logic [1:0] e,
                          output logic [127:0] a, output logic [127:0] b);
    logic [31:0] v;
    int ew = 8 << e;
    for (int k = 0; k < 16; k++) begin
      next_rand(v);
      a[127 - k*8 -: 8] = (v[1:0] == 2'd0) ? 8'h00 : 8'h40 + 8'(v[1:0]);
      next_rand(v);
      b[127 - k*8 -: 8] = (v[1:0] == 2'd0) ? 8'h00 : 8'h40 + 8'(v[1:0]);
    end
    case (p % 4)
      1: b = (a << (ew * ((p / 4) % 3 + 1))) | (a >> (128 - ew * ((p / 4) % 3 + 1)));
      2: begin
        a[127 - ((p / 4) % (128 / ew)) * ew -: 32] = '0;
        b = {16{8'hff}};
      end
      3: b = {16{8'h41}};
      default: ;
    endcase
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [127:0] a, b, held;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10: reset state
    chk(out_valid == 1'b0, "R10 reset out_valid", 128'(out_valid), 128'(0));
    chk(result == '0, "R10 reset result", result, '0);
    chk(cc == 2'd0, "R10 reset cc", 128'(cc), 128'(0));
    chk(es_err == 1'b0, "R10 reset es_err", 128'(es_err), 128'(0));

    // R1: byte 5 of A matches byte 12 of B, top-first numbering
    a = {16{8'h11}}; a[127 - 5*8 -: 8] = 8'h77;
    b = {16{8'h22}}; b[127 - 12*8 -: 8] = 8'h77;
    apply(2'd0, 3'b000, a, b);
    chk(result == {64'd5, 64'd0}, "R1 cross-position hit offset", result, {64'd5, 64'd0});
    chk(cc == 2'd1, "R6 hit without zero", 128'(cc), 128'(1));

    // R8: 16-bit elements, element 2 starts at byte 4
    a = {8{16'h1111}}; a[127 - 2*16 -: 16] = 16'h1234;
    b = {8{16'h2222}}; b[127 - 6*16 -: 16] = 16'h1234;
    apply(2'd1, 3'b000, a, b);
    chk(result == {64'd4, 64'd0}, "R8 halfword offset", result, {64'd4, 64'd0});
    // R8: 32-bit elements, misaligned halves must not hit
    a = {4{32'h0101_0202}};
    b = {4{32'h0202_0101}};
    apply(2'd2, 3'b000, a, b);
    chk(result == {64'd16, 64'd0}, "R8 word no partial hit", result, {64'd16, 64'd0});

    // R5: zero at byte 3, no hits
    a = {16{8'h31}}; a[127 - 3*8 -: 8] = 8'h00;
    b = {16{8'h55}};
    apply(2'd0, 3'b001, a, b);
    chk(result == {64'd3, 64'd0}, "R5 zero found", result, {64'd3, 64'd0});
    chk(cc == 2'd0, "R6 zero first", 128'(cc), 128'(0));
    apply(2'd0, 3'b000, a, b);
    chk(result == {64'd16, 64'd0}, "R5 zero search off", result, {64'd16, 64'd0});
    chk(cc == 2'd3, "R6 nothing found", 128'(cc), 128'(3));

    // R3: all equal, inverted -> none
    a = {16{8'h5a}};
    apply(2'd0, 3'b100, a, a);
    chk(result == {64'd16, 64'd0}, "R3 invert clears all hits", result, {64'd16, 64'd0});
    // R7: mask bit selects mask form
    apply(2'd0, 3'b010, a, a);
    chk(result == {128{1'b1}}, "R7 mask flag at bit 2", result, {128{1'b1}});

    // R11: illegal size, then recovery
    apply(2'd3, 3'b010, a, a);
    chk(es_err == 1'b1, "R11 error flag", 128'(es_err), 128'(1));
    chk(result == '0, "R11 zero result", result, '0);
    chk(cc == 2'd3, "R11 code", 128'(cc), 128'(3));
    apply(2'd0, 3'b000, a, a);
    chk(es_err == 1'b0, "R11 error clears", 128'(es_err), 128'(0));

    // R9: hold while idle
    held = result;
    @(negedge clk);
    opa = ~opa; ctrl = 3'b111;
    @(negedge clk);
    chk(out_valid == 1'b0, "R9 idle out_valid low", 128'(out_valid), 128'(0));
    chk(result == held, "R9 result held", result, held);

    // Sweep: every size, every flag set, mixed operand patterns
    for (int e = 0; e < 3; e++) begin
      for (int c = 0; c < 8; c++) begin
        for (int p = 0; p < 24; p++) begin
          make_ops(p, 2'(e), a, b);
          run_model(2'(e), 3'(c), a, b);
        end
      end
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule